// File: doc/BRIEF.md
# I2C SCL Half-Period Rate Generator

This block turns a fast source clock into the timing ticks that an I2C master needs to shape SCL. Three counters run in a chain. A fixed-ratio predivider feeds a step counter, and the step counter feeds a sample counter. Each wrap of the step counter gives a sample strobe. Each wrap of the sample counter closes one SCL half period. The bus rate is therefore the source clock divided by 2·D·S·T, where D is the predivide, S the sample count and T the step count.

Two counter pairs can be programmed. A standard/fast timing word sets one pair, and a separate high-speed word sets a second pair together with an enable code. A transaction sequencer raises `hs_sel` once the master code has been sent. The generator then switches to the high-speed pair, but only when that pair is enabled. Any change to the divider, to either word or to the mode selection waits for the next half-period boundary, so SCL never gets a shortened pulse.

Top module: `scl_rate_gen`

## Requirements
- R1: During synchronous reset `half_tick`, `sample_stb` and `hs_mode` are 0.
- R2: While `en` is low, no `half_tick` or `sample_stb` pulse appears and all counters are held at zero.
- R3: In standard/fast mode one half period lasts D·S·T source cycles, with D = `div_m1`+1, S = `timing_cfg[10:8]`+1 and T = `timing_cfg[5:0]`+1.
- R4: `sample_stb` pulses once every D·T cycles, giving S strobes per half period. Every `half_tick` coincides with a `sample_stb`.
- R5: When `hs_sel` is 1 and `hs_cfg[1:0]` = 2'b11, the high-speed pair is used: S = `hs_cfg[14:12]`+1 and T = `hs_cfg[10:8]`+1, so T is at most 8. In this mode `hs_mode` reads 1.
- R6: When `hs_sel` is 1 but `hs_cfg[1:0]` is not 2'b11, the standard/fast pair stays in use and `hs_mode` is 0.
- R7: A change of divider, timing words or mode while running lets the half period in progress finish with the old values. The new values apply from the following half period.
- R8: The smallest setting (D = S = T = 1) produces a `half_tick` on every cycle. The largest standard setting gives 8·8·64 cycles per half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the counters cleared |
| div_m1 | input | 3 | Predivide value minus one |
| timing_cfg | input | 16 | Standard/fast word: [10:8] sample minus one, [5:0] step minus one |
| hs_cfg | input | 16 | High-speed word: [14:12] sample minus one, [10:8] step minus one, [1:0] enable code 2'b11 |
| hs_sel | input | 1 | Requests the high-speed pair; raised after the master code |
| half_tick | output | 1 | One-cycle pulse at each SCL half-period boundary |
| sample_stb | output | 1 | One-cycle pulse at each step-counter wrap |
| hs_mode | output | 1 | The high-speed pair is currently active |

## Verification
Directed settings cover the extremes, all-ones and the largest product, as well as lopsided mixes where a large divider meets a small step count or the reverse. These cases separate errors in each of the three factors of the period. Seeded random configurations then exercise many D·S·T products. In each case the strobe spacing and the strobe count per half period are measured, which keeps a swapped sample and step field from going unnoticed. Further cases change the configuration, or switch `hs_sel`, right after a boundary, once with the high-speed enable code present and once without it. These show that the running half period keeps its old length, and that an incomplete enable code leaves the standard pair in use.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;
  localparam int DIV_W      = 3;
  localparam int SMP_W      = 3;
  localparam int STP_W      = 6;
  localparam int HS_STP_W   = 3;
  localparam int REG_W      = 16;
  localparam int TM_SMP_LSB = 8;
  localparam int TM_STP_LSB = 0;
  localparam int HS_SMP_LSB = 12;
  localparam int HS_STP_LSB = 8;
  localparam int HS_EN_W    = 2;
  localparam logic [HS_EN_W-1:0] HS_EN_CODE = '1;

  typedef struct packed {
    logic [DIV_W-1:0] div_m1;
    logic [SMP_W-1:0] smp_m1;
    logic [STP_W-1:0] stp_m1;
  } rate_cfg_t;
endpackage

// File: rtl/scl_cfg_sel.sv
module scl_cfg_sel
  import scl_rate_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] div_m1_i,
  input  logic [REG_W-1:0] timing_i,
  input  logic [REG_W-1:0] hs_i,
  input  logic             hs_sel_i,
  output rate_cfg_t        act_o,
  output logic             hs_act_o
);
  localparam logic [REG_W-1:0] TM_MASK =
    REG_W'(((1 << SMP_W) - 1) << TM_SMP_LSB) | REG_W'(((1 << STP_W) - 1) << TM_STP_LSB);
  localparam logic [REG_W-1:0] HS_MASK =
    REG_W'(((1 << SMP_W) - 1) << HS_SMP_LSB) | REG_W'(((1 << HS_STP_W) - 1) << HS_STP_LSB) |
    REG_W'((1 << HS_EN_W) - 1);

  logic      hs_go;
  rate_cfg_t nxt;
  logic      unused_bits;

  assign unused_bits = ^{timing_i & ~TM_MASK, hs_i & ~HS_MASK};

  always_comb begin
    hs_go      = hs_sel_i && (hs_i[HS_EN_W-1:0] == HS_EN_CODE);
    nxt.div_m1 = div_m1_i;
    if (hs_go) begin
      nxt.smp_m1 = hs_i[HS_SMP_LSB +: SMP_W];
      nxt.stp_m1 = STP_W'(hs_i[HS_STP_LSB +: HS_STP_W]);
    end else begin
      nxt.smp_m1 = timing_i[TM_SMP_LSB +: SMP_W];
      nxt.stp_m1 = timing_i[TM_STP_LSB +: STP_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_o    <= '0;
      hs_act_o <= 1'b0;
    end else if (load) begin
      act_o    <= nxt;
      hs_act_o <= hs_go;
    end
  end

  // R7: the active setting only moves on a load
  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(act_o) && $stable(hs_act_o));
endmodule

// File: rtl/scl_prediv.sv
module scl_prediv
  import scl_rate_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_m1,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)          cnt <= '0;
    else if (cnt == div_m1)   cnt <= '0;
    else                      cnt <= cnt + DIV_W'(1);
  end

  assign tick = run && (cnt == div_m1);

  assert_prediv_range_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= div_m1);
  assert_prediv_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt == '0);
endmodule

// File: rtl/scl_pair_cnt.sv
module scl_pair_cnt
  import scl_rate_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             adv,
  input  logic [SMP_W-1:0] smp_m1,
  input  logic [STP_W-1:0] stp_m1,
  output logic             stb_w,
  output logic             half_w
);
  logic [STP_W-1:0] step;
  logic [SMP_W-1:0] smp;

  assign stb_w  = adv && (step == stp_m1);
  assign half_w = stb_w && (smp == smp_m1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      step <= '0;
      smp  <= '0;
    end else if (adv) begin
      if (step == stp_m1) begin
        step <= '0;
        smp  <= (smp == smp_m1) ? '0 : smp + SMP_W'(1);
      end else begin
        step <= step + STP_W'(1);
      end
    end
  end

  assert_step_range_R3: assert property (@(posedge clk) disable iff (rst)
    step <= stp_m1 && smp <= smp_m1);
  assert_pair_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> step == '0 && smp == '0);
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_rate_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_m1,
  input  logic [REG_W-1:0] timing_cfg,
  input  logic [REG_W-1:0] hs_cfg,
  input  logic             hs_sel,
  output logic             half_tick,
  output logic             sample_stb,
  output logic             hs_mode
);
  rate_cfg_t act;
  logic      pre_tick;
  logic      stb_w;
  logic      half_w;
  logic      load;

  // reload while idle, or exactly at the close of a half period
  assign load = !en || half_w;

  scl_cfg_sel u_sel (
    .clk(clk), .rst(rst), .load(load),
    .div_m1_i(div_m1), .timing_i(timing_cfg), .hs_i(hs_cfg), .hs_sel_i(hs_sel),
    .act_o(act), .hs_act_o(hs_mode)
  );

  scl_prediv u_pre (
    .clk(clk), .rst(rst), .run(en), .div_m1(act.div_m1), .tick(pre_tick)
  );

  scl_pair_cnt u_pair (
    .clk(clk), .rst(rst), .run(en), .adv(pre_tick),
    .smp_m1(act.smp_m1), .stp_m1(act.stp_m1),
    .stb_w(stb_w), .half_w(half_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      half_tick  <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      half_tick  <= half_w;
      sample_stb <= stb_w;
    end
  end

  assert_half_has_stb_R4: assert property (@(posedge clk) disable iff (rst)
    half_tick |-> sample_stb);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> !half_tick && !sample_stb);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> !half_tick && !sample_stb && !hs_mode);
endmodule

// File: tb/scl_rate_gen_test.sv
module scl_rate_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [2:0]  div_m1 = '0;
  logic [15:0] timing_cfg = '0;
  logic [15:0] hs_cfg = '0;
  logic        hs_sel = 1'b0;
  logic        half_tick, sample_stb, hs_mode;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  scl_rate_gen uut (
    .clk(clk), .rst(rst), .en(en), .div_m1(div_m1), .timing_cfg(timing_cfg),
    .hs_cfg(hs_cfg), .hs_sel(hs_sel), .half_tick(half_tick),
    .sample_stb(sample_stb), .hs_mode(hs_mode)
  );

  function automatic logic [15:0] tm_word(int s, int t);
    return 16'(((s - 1) << 8) | (t - 1));
  endfunction
  function automatic logic [15:0] hs_word(int s, int t, int code);
    return 16'(((s - 1) << 12) | ((t - 1) << 8) | code);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      finish_run();
    end
  end

  task automatic apply(int d, logic [15:0] tw, logic [15:0] hw, logic sel);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    div_m1 = 3'(d - 1); timing_cfg = tw; hs_cfg = hw; hs_sel = sel;
    @(negedge clk); en = 1'b1;
  endtask

  task automatic sync();
    int k = 0;
    do begin @(negedge clk); k++; end while (!half_tick && k < 40000);
  endtask

  // counts from just after a half tick up to and including the next one
  task automatic one_period(input int exp_gap, output int len, output int nstb, output int bad);
    int gap = 0;
    len = 0; nstb = 0; bad = 0;
    do begin
      @(negedge clk); len++; gap++;
      if (sample_stb) begin
        nstb++;
        if (gap != exp_gap) bad++;
        gap = 0;
      end
    end while (!half_tick && len < 40000);
  endtask

  task automatic check_period(string req, int d, int s, int t);
    int len, nstb, bad;
    one_period(d * t, len, nstb, bad);
    chk(len == d * s * t, req, len, d * s * t);
    chk(nstb == s && bad == 0, "R4", nstb * 1000 + bad, s * 1000);
  endtask

  task automatic run_sf(string req, int d, int s, int t);
    apply(d, tm_word(s, t), 16'h0000, 1'b0);
    sync();
    check_period(req, d, s, t);
    check_period(req, d, s, t);
  endtask

  initial begin
    int quiet;
    void'($urandom(32'd1234));
    en = 1'b1;
    repeat (4) @(negedge clk);
    chk(!half_tick && !sample_stb && !hs_mode, "R1", {half_tick, sample_stb, hs_mode}, 0);
    rst = 1'b0;
    en = 1'b0; div_m1 = 3'd4; timing_cfg = tm_word(2, 3);

    // R2: held idle
    quiet = 0;
    repeat (60) begin @(negedge clk); if (half_tick || sample_stb) quiet++; end
    chk(quiet == 0, "R2", quiet, 0);

    // R3 / R8 directed
    run_sf("R8", 1, 1, 1);
    run_sf("R3", 5, 2, 3);
    run_sf("R3", 8, 1, 2);
    run_sf("R3", 1, 8, 64);
    run_sf("R8", 8, 8, 64);
    for (int i = 0; i < 8; i++) begin
      int d = $urandom_range(1, 8);
      int s = $urandom_range(1, 8);
      int t = $urandom_range(1, 16);
      run_sf("R3", d, s, t);
    end

    // R2 again after running: disable and look for silence
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    quiet = 0;
    repeat (40) begin @(negedge clk); if (half_tick || sample_stb) quiet++; end
    chk(quiet == 0, "R2", quiet, 0);

    // R5: high-speed pair selected
    apply(2, tm_word(4, 10), hs_word(3, 5, 3), 1'b1);
    sync();
    chk(hs_mode == 1'b1, "R5", hs_mode, 1);
    check_period("R5", 2, 3, 5);
    apply(1, tm_word(4, 10), hs_word(8, 8, 3), 1'b1);
    sync();
    check_period("R5", 1, 8, 8);

    // R6: enable code incomplete
    apply(2, tm_word(4, 10), hs_word(3, 5, 1), 1'b1);
    sync();
    chk(hs_mode == 1'b0, "R6", hs_mode, 0);
    check_period("R6", 2, 4, 10);

    // R7: new word mid-run waits for boundary
    apply(3, tm_word(2, 4), 16'h0000, 1'b0);
    sync();
    div_m1 = 3'd1; timing_cfg = tm_word(5, 3);
    check_period("R7", 3, 2, 4);
    check_period("R7", 2, 5, 3);

    // R7 with mode switch after master code
    apply(4, tm_word(2, 6), hs_word(2, 3, 3), 1'b0);
    sync();
    hs_sel = 1'b1;
    check_period("R7", 4, 2, 6);
    chk(hs_mode == 1'b1, "R7", hs_mode, 1);
    check_period("R7", 4, 2, 3);

    finish_run();
  end
endmodule